// File: doc/BRIEF.md
# Powerdown Exit and Wake Sequencer

This block decides when a processor core may run again after it has been placed in a low-power powerdown state. The core asks for powerdown with a one-cycle request, which it raises when it executes an idle instruction with powerdown enabled. The block holds the core stopped for one more clock cycle so the entry handshake can finish. It then waits for one of two wake events. The first is a pulse on a dedicated exit pin, after which the core resumes at its saved address once a startup count has run. The second is a low pulse on the active-low reset pin, which restarts the core at address zero and may ask a boot loader to run.

The two wake paths follow different rules. The reset path requires a minimum low width before it counts as an exit. That width is short when the input clock kept running at the same frequency, and much longer when the clock was stopped or changed, because the oscillator must settle and the PLL must lock. The reset path never uses the delayed-startup control bit. The pin path adds an oscillator-settle count before its startup count when the delayed-startup bit is set. While the core is in powerdown, the crystal pin drive can be switched off by a control bit.

The states are RUN, ENTERING, POWERDOWN, WAKE_COUNT and RESET_HOLD. The transitions are:
- RUN to ENTERING on a request.
- ENTERING to POWERDOWN always.
- POWERDOWN to RESET_HOLD when reset goes low.
- POWERDOWN to WAKE_COUNT on the exit pin.
- RESET_HOLD to WAKE_COUNT on a release after a wide enough low pulse.
- RESET_HOLD to POWERDOWN on a release after a low pulse that is too short.
- WAKE_COUNT to RESET_HOLD when reset goes low.
- WAKE_COUNT to RUN when the count expires.

Top module: `pwrdn_wake_seq`

## Requirements
- R1: After the block's own power-on reset, `core_run` is 1, `fetch_addr` is 0, `xtal_drive` is 1 and `boot_start` is 0. `core_run` is 1 only in RUN.
- R2: When `pd_req` is sampled high in RUN, `core_run` is 0 from the next cycle onward. The block spends exactly one cycle in ENTERING before POWERDOWN, and `resume_pc` is captured at that request edge.
- R3: With `clk_was_stopped` = 0, a low pulse on `rst_pin_n` that lasts 5 or more clock cycles during powerdown is an exit. A pulse of 1 to 4 cycles is ignored: the block returns to POWERDOWN and `core_run` stays 0.
- R4: With `clk_was_stopped` = 1, the reset low width needed for an exit is the settle count plus the lock count, which is 2000 + 1000 = 3000 cycles by default. A pulse of 2999 cycles is ignored.
- R5: On a reset exit, `core_run` rises exactly 100 cycles after the edge that samples the release, and `fetch_addr` is 0. If `boot_strap` was 0 at the release edge, `boot_start` is high for exactly the first RUN cycle; if it was 1, `boot_start` stays 0.
- R6: A reset exit ignores `slow_start`: the startup count is 100 cycles even when `slow_start` is 1.
- R7: `xtal_drive` is 0 only while in POWERDOWN with `xtal_off` = 1. In every other case it is 1.
- R8: A pin exit (`wake_pin` sampled high in POWERDOWN) raises `core_run` exactly 100 cycles after that edge, or 2100 cycles after it if `slow_start` is 1. `fetch_addr` then equals the captured `resume_pc`, and no boot pulse occurs.
- R9: A low level on `rst_pin_n` during WAKE_COUNT takes priority over the pin exit in progress and moves the block to RESET_HOLD. A qualifying release then gives a vector-zero restart.
- R10: The reset width counter saturates at its largest hold requirement. A hold far longer than needed still gives a normal exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| por_n | input | 1 | Block power-on reset, active low, asynchronous |
| pd_req | input | 1 | Powerdown request from the core (idle with powerdown enabled) |
| wake_pin | input | 1 | Powerdown exit pin, active high |
| rst_pin_n | input | 1 | External reset pin, active low |
| boot_strap | input | 1 | Boot-mode strap; 0 requests a boot after a reset exit |
| xtal_off | input | 1 | Control bit: stop driving the crystal pin during powerdown |
| slow_start | input | 1 | Control bit: add oscillator settle time to a pin exit |
| clk_was_stopped | input | 1 | Status: the clock stopped or changed frequency during powerdown |
| resume_pc | input | ADDR_W | Address at which to resume after a pin exit |
| core_run | output | 1 | Core run enable |
| xtal_drive | output | 1 | Crystal pin drive enable |
| boot_start | output | 1 | One-cycle boot start pulse |
| fetch_addr | output | ADDR_W | Start address for instruction fetch |

## Verification
The bench enters powerdown repeatedly and uses random choices between three kinds of exit: a pin exit, a reset exit, and a reset that arrives during a pin wake count. The random choices also cover the delayed-startup bit, the crystal-disable bit, the boot strap and the resume address. Pin exits with the delayed bit on and off separate the two startup lengths. Reset exits with the delayed bit set show that the bit is ignored on that path. Random reset widths on both sides of 5 cycles, together with directed holds of 2999 and 3050 cycles with the stopped-clock status set, separate accepted pulses from ignored ones and exercise the saturating width count. The exact cycle at which `core_run` rises, and the value of `fetch_addr` at that cycle, separate a resume exit from a vector-zero restart.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_ENTERING,
        ST_POWERDOWN,
        ST_WAKE_COUNT,
        ST_RESET_HOLD
    } pd_state_e;
endpackage

// File: rtl/pwrdn_rst_width.sv
// Saturating counter of consecutive reset-low cycles.
module pwrdn_rst_width #(
    parameter int CW  = 12,
    parameter int SAT = 3000
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          en,
    input  logic          low,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (!en || !low) begin
            cnt <= '0;
        end else if (cnt != SAT_V) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwrdn_wake_timer.sv
// Down counter: after a load of N it reports done in the N-th counting cycle.
module pwrdn_wake_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          en,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - 1'b1;
        end else if (en && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pwrdn_wake_seq.sv
module pwrdn_wake_seq
    import pwrdn_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int FAST_HOLD  = 5,
    parameter int SETTLE_CYC = 2000,
    parameter int LOCK_CYC   = 1000,
    parameter int START_CYC  = 100
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              pd_req,
    input  logic              wake_pin,
    input  logic              rst_pin_n,
    input  logic              boot_strap,
    input  logic              xtal_off,
    input  logic              slow_start,
    input  logic              clk_was_stopped,
    input  logic [ADDR_W-1:0] resume_pc,
    output logic              core_run,
    output logic              xtal_drive,
    output logic              boot_start,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam int SLOW_HOLD = SETTLE_CYC + LOCK_CYC;
    localparam int HOLD_MAX  = (SLOW_HOLD > FAST_HOLD) ? SLOW_HOLD : FAST_HOLD;
    localparam int CW        = $clog2(HOLD_MAX + 1);
    localparam int TW        = $clog2(SETTLE_CYC + START_CYC + 1);

    localparam logic [CW-1:0] FAST_V   = CW'(FAST_HOLD);
    localparam logic [CW-1:0] SLOW_V   = CW'(SLOW_HOLD);
    localparam logic [TW-1:0] START_V  = TW'(START_CYC);
    localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC);

    pd_state_e         state, next;
    logic [CW-1:0]     wcnt;
    logic [CW-1:0]     hold_need;
    logic              rst_low, width_ok;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;
    logic              pin_exit, rst_exit;
    logic              via_reset, want_boot, fresh_run;
    logic [ADDR_W-1:0] addr_q;

    assign rst_low   = !rst_pin_n;
    assign hold_need = clk_was_stopped ? SLOW_V : FAST_V;
    assign width_ok  = (wcnt >= hold_need);
    assign pin_exit  = (state == ST_POWERDOWN) && !rst_low && wake_pin;
    assign rst_exit  = (state == ST_RESET_HOLD) && !rst_low && width_ok;
    assign tmr_load  = pin_exit || rst_exit;
    assign tmr_val   = rst_exit ? START_V
                                : (slow_start ? START_V + SETTLE_V : START_V);

    pwrdn_rst_width #(.CW(CW), .SAT(HOLD_MAX)) u_width (
        .clk   (clk),
        .por_n (por_n),
        .en    (state != ST_RUN),
        .low   (rst_low),
        .cnt   (wcnt)
    );

    pwrdn_wake_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .por_n    (por_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .en       (state == ST_WAKE_COUNT),
        .done     (tmr_done)
    );

    // Next-state selection
    always_comb begin
        next = state;
        unique case (state)
            ST_RUN:        if (pd_req) next = ST_ENTERING;
            ST_ENTERING:   next = ST_POWERDOWN;
            ST_POWERDOWN: begin
                if (rst_low)       next = ST_RESET_HOLD;
                else if (wake_pin) next = ST_WAKE_COUNT;
            end
            ST_RESET_HOLD: begin
                if (!rst_low) next = width_ok ? ST_WAKE_COUNT : ST_POWERDOWN;
            end
            ST_WAKE_COUNT: begin
                if (rst_low)       next = ST_RESET_HOLD;
                else if (tmr_done) next = ST_RUN;
            end
            default:       next = ST_RUN;
        endcase
    end

    // State register and wake context
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state     <= ST_RUN;
            addr_q    <= '0;
            via_reset <= 1'b0;
            want_boot <= 1'b0;
            fresh_run <= 1'b0;
        end else begin
            state     <= next;
            fresh_run <= (state == ST_WAKE_COUNT) && (next == ST_RUN);
            if (state == ST_RUN && pd_req) begin
                addr_q <= resume_pc;
            end
            if (pin_exit) begin
                via_reset <= 1'b0;
                want_boot <= 1'b0;
            end else if (rst_exit) begin
                via_reset <= 1'b1;
                want_boot <= !boot_strap;
                addr_q    <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        core_run   = (state == ST_RUN);
        xtal_drive = !((state == ST_POWERDOWN) && xtal_off);
        boot_start = (state == ST_RUN) && fresh_run && via_reset && want_boot;
        fetch_addr = addr_q;
    end
endmodule

// File: rtl/pwrdn_wake_chk.sv
module pwrdn_wake_chk
    import pwrdn_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CW        = 12,
    parameter int HOLD_MAX  = 3000,
    parameter int FAST_HOLD = 5
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_pin_n,
    input pd_state_e         state,
    input logic [CW-1:0]     wcnt,
    input logic              core_run,
    input logic              xtal_drive,
    input logic              boot_start,
    input logic [ADDR_W-1:0] fetch_addr
);
    AST_ENTRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        state == ST_ENTERING |=> state == ST_POWERDOWN); // R2

    AST_SHORT_PULSE_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RESET_HOLD && rst_pin_n && wcnt < CW'(FAST_HOLD)) |=> state == ST_POWERDOWN); // R3

    AST_BOOT_AT_VECTOR: assert property (@(posedge clk) disable iff (!por_n)
        boot_start |-> (core_run && fetch_addr == '0)); // R5

    AST_BOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        boot_start |=> !boot_start); // R5

    AST_XTAL_OFF_IN_PD: assert property (@(posedge clk) disable iff (!por_n)
        !xtal_drive |-> state == ST_POWERDOWN); // R7

    AST_RUN_AFTER_COUNT: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_run) |-> $past(state) == ST_WAKE_COUNT); // R8

    AST_RESET_PRIORITY: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_WAKE_COUNT && !rst_pin_n) |=> state == ST_RESET_HOLD); // R9

    AST_WIDTH_SATURATES: assert property (@(posedge clk) disable iff (!por_n)
        wcnt <= CW'(HOLD_MAX)); // R10
endmodule

bind pwrdn_wake_seq pwrdn_wake_chk #(
    .ADDR_W    (ADDR_W),
    .CW        (CW),
    .HOLD_MAX  (HOLD_MAX),
    .FAST_HOLD (FAST_HOLD)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin_n  (rst_pin_n),
    .state      (state),
    .wcnt       (wcnt),
    .core_run   (core_run),
    .xtal_drive (xtal_drive),
    .boot_start (boot_start),
    .fetch_addr (fetch_addr)
);

// File: tb/sim_pwrdn_wake_seq.sv
module sim_pwrdn_wake_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          pd_req = 1'b0, wake_pin = 1'b0, rst_pin_n = 1'b1;
    logic          boot_strap = 1'b1, xtal_off = 1'b0, slow_start = 1'b0;
    logic          clk_was_stopped = 1'b0;
    logic [AW-1:0] resume_pc = '0;
    logic          core_run, xtal_drive, boot_start;
    logic [AW-1:0] fetch_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwrdn_wake_seq u0 (
        .clk(clk), .por_n(por_n), .pd_req(pd_req), .wake_pin(wake_pin),
        .rst_pin_n(rst_pin_n), .boot_strap(boot_strap), .xtal_off(xtal_off),
        .slow_start(slow_start), .clk_was_stopped(clk_was_stopped),
        .resume_pc(resume_pc), .core_run(core_run), .xtal_drive(xtal_drive),
        .boot_start(boot_start), .fetch_addr(fetch_addr)
    );

    function automatic int exp_hold(bit stopped);
        return stopped ? 3000 : 5;
    endfunction

    function automatic int exp_wake(bit by_reset, bit slow);
        return (!by_reset && slow) ? 2100 : 100;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic enter_pd(logic [AW-1:0] pc, bit xoff);
        xtal_off = xoff;
        pd_req = 1'b1;
        resume_pc = pc;
        cyc(1);
        pd_req = 1'b0;
        resume_pc = ~pc;
        chk(core_run == 1'b0, "R2 core stops after request", core_run, 0);
        cyc(1);
        chk(xtal_drive == !xoff, "R7 crystal drive in powerdown", xtal_drive, !xoff);
    endtask

    task automatic expect_wake(int len, logic [AW-1:0] addr, bit bootp, string req);
        cyc(len - 1);
        chk(core_run == 1'b0, req, core_run, 0);
        cyc(1);
        chk(core_run == 1'b1, req, core_run, 1);
        chk(fetch_addr == addr, req, fetch_addr, addr);
        chk(boot_start == bootp, "R5 boot pulse", boot_start, bootp);
        chk(xtal_drive == 1'b1, "R7 crystal driven in RUN", xtal_drive, 1);
        cyc(1);
        chk(boot_start == 1'b0, "R5 boot pulse ends", boot_start, 0);
    endtask

    task automatic pin_exit(bit slow, logic [AW-1:0] pc);
        slow_start = slow;
        wake_pin = 1'b1;
        cyc(1);
        wake_pin = 1'b0;
        expect_wake(exp_wake(0, slow), pc, 1'b0, "R8 pin exit timing/address");
    endtask

    task automatic reset_exit(int width, bit stopped, bit strap, bit slow, logic [AW-1:0] pc);
        clk_was_stopped = stopped;
        boot_strap = strap;
        slow_start = slow;
        rst_pin_n = 1'b0;
        cyc(width);
        rst_pin_n = 1'b1;
        cyc(1);
        if (width >= exp_hold(stopped)) begin
            expect_wake(exp_wake(1, slow), '0, !strap,
                        stopped ? "R4 slow hold exit" : "R3 R6 reset exit timing");
        end else begin
            cyc(150);
            chk(core_run == 1'b0, stopped ? "R4 short hold ignored" : "R3 short pulse ignored",
                core_run, 0);
            chk(xtal_drive == !xtal_off, "R3 back in powerdown", xtal_drive, !xtal_off);
            pin_exit(1'b0, pc);
        end
        clk_was_stopped = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        cyc(3);
        por_n = 1'b1;
        cyc(1);
        chk(core_run == 1'b1, "R1 reset core_run", core_run, 1);
        chk(fetch_addr == '0, "R1 reset fetch_addr", fetch_addr, 0);
        chk(xtal_drive == 1'b1, "R1 reset xtal_drive", xtal_drive, 1);
        chk(boot_start == 1'b0, "R1 reset boot_start", boot_start, 0);

        // Directed corners
        enter_pd(16'h1234, 1'b1);
        pin_exit(1'b0, 16'h1234);
        enter_pd(16'h0BEE, 1'b0);
        pin_exit(1'b1, 16'h0BEE);
        enter_pd(16'h0042, 1'b1);
        reset_exit(4, 1'b0, 1'b0, 1'b0, 16'h0042);
        enter_pd(16'h0043, 1'b0);
        reset_exit(5, 1'b0, 1'b0, 1'b1, 16'h0043);
        enter_pd(16'h0044, 1'b1);
        reset_exit(2999, 1'b1, 1'b1, 1'b0, 16'h0044);
        enter_pd(16'h0045, 1'b0);
        reset_exit(3050, 1'b1, 1'b0, 1'b0, 16'h0045);  // R10 saturated hold

        // Constrained random trials
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] pc;
            int kind;
            pc = AW'($urandom_range(1, 65535));
            kind = $urandom_range(0, 2);
            enter_pd(pc, 1'($urandom_range(0, 1)));
            if (kind == 0) begin
                pin_exit(1'($urandom_range(0, 1)), pc);
            end else if (kind == 1) begin
                reset_exit($urandom_range(1, 9), 1'b0, 1'($urandom_range(0, 1)),
                           1'($urandom_range(0, 1)), pc);
            end else begin
                // R9: reset during a pin wake count wins
                slow_start = 1'($urandom_range(0, 1));
                boot_strap = 1'($urandom_range(0, 1));
                wake_pin = 1'b1;
                cyc(1);
                wake_pin = 1'b0;
                cyc($urandom_range(2, 60));
                rst_pin_n = 1'b0;
                cyc(6);
                rst_pin_n = 1'b1;
                cyc(1);
                expect_wake(100, '0, !boot_strap, "R9 reset overrides pin wake");
            end
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule